// File: doc/BRIEF.md
# Auxiliary 8-bit peripheral bus bridge

This block lets a host reach slow byte-wide peripherals through single register accesses. The host hands over one request: read or write, a 3-bit device index, a 3-bit register address and a write byte. The block then runs one strobed cycle on the peripheral bus. The sequence is chip select and address setup, then a read or write strobe, then a hold clock. After the hold clock the block returns an acknowledge, together with the read byte and an error flag.

The peripheral sets the length of the strobe. A high ready input ends the strobe, and a wait input keeps it going even when ready is high. If a peripheral never responds, an internal timer ends the cycle and flags a timeout. This keeps a broken device from stalling the host.

Two peripheral interrupt lines are edge-detected. Each rising edge latches into a status bit that stays set until the host writes a 1 to that bit. A single interrupt output reports whether any status bit that is also enabled is set.

Top module: `aux_bridge`

## Requirements
- R1: While reset is asserted and just after it is released, all chip selects, both strobes, `host_ack`, `host_err`, `irq_status` and `irq_out` are inactive. Active-low outputs are high and the other outputs are 0.
- R2: During a cycle exactly one chip-select bit is low, and it is bit `host_dev` (so `pb_cs_n == ~(1 << host_dev)`). `pb_addr` equals the requested address for the whole cycle. Outside a cycle `pb_cs_n` is all ones.
- R3: A cycle runs in order. First comes one clock with chip select and address driven and both strobes high. Then come the strobe clocks. Then comes one clock with chip select still low and both strobes high. Then `host_ack` pulses for one clock with chip select released.
- R4: A read (`host_we = 0`) drives only `pb_rd_n` low. A write (`host_we = 1`) drives only `pb_wr_n` low and presents the write byte on `pb_wdata` with `pb_wdata_oe = 1` for the whole cycle.
- R5: The strobe stays low until a clock edge at which `pb_ready = 1` and `pb_hold = 0`. It goes high right after that edge, so a peripheral that is ready at once gives a one-clock strobe.
- R6: While `pb_hold = 1` the strobe stays low even if `pb_ready = 1`. The strobe length in clocks equals the number of clocks until the first clock with ready high and hold low, plus one.
- R7: Read data is sampled from `pb_rdata` at the edge that ends the strobe. It is presented on `host_rdata` from the acknowledge onward and held until the next read completes.
- R8: If the strobe has lasted TIMEOUT (256) clocks without completing, the cycle is aborted through the normal hold clock and acknowledge. `host_err` is set, and a read returns 0xFF. `host_err` clears when the next request is accepted.
- R9: A request raised while a cycle is in progress is ignored. The chip select of the running cycle is unchanged, only one acknowledge occurs, and no further cycle follows.
- R10: A 0-to-1 change on `pb_irq[i]`, seen at a clock edge, sets `irq_status[i]` at that edge. A line held high does not set it again. A 1 on `irq_clr[i]` clears the bit, and a new edge in the same clock wins over the clear.
- R11: `irq_out` is 1 exactly when some bit is set in both `irq_status` and `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-clock request pulse, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_dev | input | 3 | Device index selecting the chip select |
| host_addr | input | 3 | Register address on the peripheral |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 8 | Read byte (0xFF after a read timeout) |
| host_err | output | 1 | Timeout flag of the last cycle |
| irq_en | input | 2 | Enable mask for the interrupt output |
| irq_clr | input | 2 | Write-1-to-clear pulses for status bits |
| irq_status | output | 2 | Latched interrupt edges |
| irq_out | output | 1 | OR of enabled status bits |
| pb_cs_n | output | 8 | Chip selects, active low |
| pb_addr | output | 3 | Peripheral address |
| pb_wdata | output | 8 | Peripheral write data |
| pb_wdata_oe | output | 1 | Write data drive enable |
| pb_rdata | input | 8 | Peripheral read data |
| pb_rd_n | output | 1 | Read strobe, active low |
| pb_wr_n | output | 1 | Write strobe, active low |
| pb_ready | input | 1 | Peripheral ready, active high |
| pb_hold | input | 1 | Peripheral wait request, active high |
| pb_irq | input | 2 | Interrupt lines, rising-edge triggered |

## Verification
The assertions assume that `pb_irq`, `pb_ready` and `pb_hold` are already synchronous to `clk`. They also assume that `host_req` is a one-clock pulse. The bench respects both assumptions by changing every input on the falling edge only.

The bench's peripheral model raises ready and hold only while a strobe is low, following a per-access delay schedule. It presents a false data byte in every strobe clock except the one that ends the strobe, so a read sampled at any other edge shows up. Interrupt lines are raised and dropped between rising edges, which gives each edge a well-defined sampling clock.

// File: rtl/aux_pkg.sv
package aux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } aux_state_e;
endpackage

// File: rtl/aux_cycle_ctrl.sv
module aux_cycle_ctrl
    import aux_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 3,
    parameter int DEVS    = 8,
    parameter int TIMEOUT = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  logic [$clog2(DEVS)-1:0]  dev,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic                     ack,
    output logic [DW-1:0]            rdata,
    output logic                     err,
    output logic [DEVS-1:0]          cs_n,
    output logic [AW-1:0]            pb_addr,
    output logic [DW-1:0]            pb_wdata,
    output logic                     pb_wdata_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    input  logic [DW-1:0]            pb_rdata,
    input  logic                     pb_ready,
    input  logic                     pb_hold
);
    localparam int DIW = $clog2(DEVS);
    localparam int TW  = $clog2(TIMEOUT);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    typedef struct packed {
        aux_state_e     state;
        logic           we;
        logic [DIW-1:0] dev;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [TW-1:0]  cnt;
        logic [DW-1:0]  rdata;
        logic           err;
        logic           ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic done_w;

    assign done_w = pb_ready && !pb_hold;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.state = ST_SETUP;
                    ctl_d.we    = we;
                    ctl_d.dev   = dev;
                    ctl_d.addr  = addr;
                    ctl_d.wdata = wdata;
                    ctl_d.cnt   = '0;
                    ctl_d.err   = 1'b0;
                end
            end
            ST_SETUP: begin
                ctl_d.state = ST_STROBE;
            end
            ST_STROBE: begin
                if (done_w) begin
                    if (!ctl_q.we) begin
                        ctl_d.rdata = pb_rdata;
                    end
                    ctl_d.state = ST_HOLD;
                end else if (ctl_q.cnt == LAST) begin
                    ctl_d.err = 1'b1;
                    if (!ctl_q.we) begin
                        ctl_d.rdata = '1;
                    end
                    ctl_d.state = ST_HOLD;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                ctl_d.state = ST_IDLE;
                ctl_d.ack   = 1'b1;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < DEVS; g++) begin : g_cs
        assign cs_n[g] = !((ctl_q.state != ST_IDLE) && (ctl_q.dev == DIW'(g)));
    end

    assign pb_addr     = ctl_q.addr;
    assign pb_wdata    = ctl_q.wdata;
    assign pb_wdata_oe = (ctl_q.state != ST_IDLE) && ctl_q.we;
    assign rd_n        = !((ctl_q.state == ST_STROBE) && !ctl_q.we);
    assign wr_n        = !((ctl_q.state == ST_STROBE) && ctl_q.we);
    assign ack         = ctl_q.ack;
    assign rdata       = ctl_q.rdata;
    assign err         = ctl_q.err;

    a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> ($past(cs_n) != '1));

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && pb_ready && !pb_hold) |=> (rd_n && wr_n));

    a_r6_hold_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_n || !wr_n) && pb_hold && ctl_q.cnt != LAST) |=> (!rd_n || !wr_n));

    a_r3_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs_n == '1 && $past(rd_n) && $past(wr_n)));
endmodule

// File: rtl/aux_irq_latch.sv
module aux_irq_latch #(
    parameter int NIRQ = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_in,
    input  logic [NIRQ-1:0] en,
    input  logic [NIRQ-1:0] clr,
    output logic [NIRQ-1:0] status,
    output logic            irq_out
);
    typedef struct packed {
        logic [NIRQ-1:0] prev;
        logic [NIRQ-1:0] status;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d        = irq_q;
        irq_d.prev   = irq_in;
        irq_d.status = (irq_q.status & ~clr) | (irq_in & ~irq_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign status  = irq_q.status;
    assign irq_out = |(irq_q.status & en);

    for (genvar i = 0; i < NIRQ; i++) begin : g_chk
        a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[i] && !irq_q.prev[i]) |=> status[i]);
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]);
        a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[i] && !(irq_in[i] && !irq_q.prev[i])) |=> !status[i]);
    end
endmodule

// File: rtl/aux_bridge.sv
module aux_bridge #(
    parameter int DW      = 8,
    parameter int AW      = 3,
    parameter int DEVS    = 8,
    parameter int NIRQ    = 2,
    parameter int TIMEOUT = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [$clog2(DEVS)-1:0] host_dev,
    input  logic [AW-1:0]           host_addr,
    input  logic [DW-1:0]           host_wdata,
    output logic                    host_ack,
    output logic [DW-1:0]           host_rdata,
    output logic                    host_err,
    input  logic [NIRQ-1:0]         irq_en,
    input  logic [NIRQ-1:0]         irq_clr,
    output logic [NIRQ-1:0]         irq_status,
    output logic                    irq_out,
    output logic [DEVS-1:0]         pb_cs_n,
    output logic [AW-1:0]           pb_addr,
    output logic [DW-1:0]           pb_wdata,
    output logic                    pb_wdata_oe,
    input  logic [DW-1:0]           pb_rdata,
    output logic                    pb_rd_n,
    output logic                    pb_wr_n,
    input  logic                    pb_ready,
    input  logic                    pb_hold,
    input  logic [NIRQ-1:0]         pb_irq
);
    aux_cycle_ctrl #(
        .DW(DW), .AW(AW), .DEVS(DEVS), .TIMEOUT(TIMEOUT)
    ) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .we         (host_we),
        .dev        (host_dev),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .ack        (host_ack),
        .rdata      (host_rdata),
        .err        (host_err),
        .cs_n       (pb_cs_n),
        .pb_addr    (pb_addr),
        .pb_wdata   (pb_wdata),
        .pb_wdata_oe(pb_wdata_oe),
        .rd_n       (pb_rd_n),
        .wr_n       (pb_wr_n),
        .pb_rdata   (pb_rdata),
        .pb_ready   (pb_ready),
        .pb_hold    (pb_hold)
    );

    aux_irq_latch #(
        .NIRQ(NIRQ)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (pb_irq),
        .en     (irq_en),
        .clr    (irq_clr),
        .status (irq_status),
        .irq_out(irq_out)
    );
endmodule

// File: tb/tb_aux_bridge.sv
module tb_aux_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0, host_we = 1'b0;
    logic [2:0] host_dev = '0, host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_ack, host_err;
    logic [7:0] host_rdata;
    logic [1:0] irq_en = '0, irq_clr = '0, irq_status, pb_irq = '0;
    logic       irq_out;
    logic [7:0] pb_cs_n, pb_wdata, pb_rdata = '0;
    logic [2:0] pb_addr;
    logic       pb_wdata_oe, pb_rd_n, pb_wr_n;
    logic       pb_ready = 1'b0, pb_hold = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    aux_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_dev(host_dev),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_err(host_err),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status), .irq_out(irq_out),
        .pb_cs_n(pb_cs_n), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
        .pb_wdata_oe(pb_wdata_oe), .pb_rdata(pb_rdata),
        .pb_rd_n(pb_rd_n), .pb_wr_n(pb_wr_n),
        .pb_ready(pb_ready), .pb_hold(pb_hold), .pb_irq(pb_irq)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] dev;
        logic [2:0] addr;
        logic [7:0] wd;
        logic [7:0] model;
        logic [3:0] rdly;
        logic [3:0] wx;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 3'd5, 8'h00, 8'hA5, 4'd0, 4'd0},
        '{1'b1, 3'd7, 3'd2, 8'h3C, 8'h00, 4'd2, 4'd0},
        '{1'b0, 3'd3, 3'd7, 8'h00, 8'h5A, 4'd1, 4'd3},
        '{1'b1, 3'd5, 3'd0, 8'hC3, 8'h00, 4'd0, 4'd2},
        '{1'b0, 3'd6, 3'd1, 8'h00, 8'h81, 4'd4, 4'd1},
        '{1'b1, 3'd1, 3'd4, 8'h7E, 8'h00, 4'd1, 4'd0}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One host access with a peripheral model; rdly/wx set ready/hold timing.
    task automatic run_access(input bit we, input int dev, input int addr,
                              input int wd, input int model, input int rdly,
                              input int wx, input bit exp_err, input bit poke);
        int stb = 0;
        int cs_cycles = 0;
        int guard = 0;
        bit setup_ok = 1;
        bit bad_cs = 0, bad_addr = 0, bad_wr = 0, bad_strobe = 0;
        int exp_stb;
        exp_stb = (rdly >= 1000) ? 256 : rdly + wx + 1;
        @(negedge clk);
        host_req = 1; host_we = we; host_dev = 3'(dev);
        host_addr = 3'(addr); host_wdata = 8'(wd);
        @(negedge clk);
        host_req = 0;
        // first sampled clock must be setup: cs low, no strobe (R3)
        if (pb_cs_n == 8'hFF || !pb_rd_n || !pb_wr_n) setup_ok = 0;
        while (!host_ack && guard < 400) begin
            host_req = 0;
            if (pb_cs_n != 8'hFF) begin
                cs_cycles++;
                if (pb_cs_n != ~(8'd1 << dev)) bad_cs = 1;
                if (pb_addr != 3'(addr)) bad_addr = 1;
                if (we && (!pb_wdata_oe || pb_wdata != 8'(wd))) bad_wr = 1;
            end
            if (!pb_rd_n || !pb_wr_n) begin
                if (we ? !pb_rd_n : !pb_wr_n) bad_strobe = 1;
                pb_ready = (stb >= rdly);
                pb_hold  = (stb < rdly + wx);
                pb_rdata = (pb_ready && !pb_hold) ? 8'(model) : ~8'(model);
                if (poke && stb == 0) begin
                    host_req = 1; host_dev = 3'(dev) ^ 3'd1; host_we = ~we;
                end
                stb++;
            end else begin
                pb_ready = 0; pb_hold = 0; pb_rdata = 8'h00;
            end
            @(negedge clk);
            guard++;
        end
        host_req = 0; pb_ready = 0; pb_hold = 0;
        chk(host_ack, "R3", "ack seen", host_ack, 1);
        chk(setup_ok, "R3", "setup clock", setup_ok, 1);
        chk(pb_cs_n == 8'hFF, "R3", "cs released at ack", pb_cs_n, 8'hFF);
        chk(cs_cycles == stb + 2, "R3", "cs clocks vs strobe", cs_cycles, stb + 2);
        chk(!bad_cs, "R2", "one-hot cs", bad_cs, 0);
        chk(!bad_addr, "R2", "address", bad_addr, 0);
        chk(!bad_wr, "R4", "write data/oe", bad_wr, 0);
        chk(!bad_strobe, "R4", "strobe kind", bad_strobe, 0);
        if (rdly >= 1000)
            chk(stb == exp_stb, "R8", "timeout strobe length", stb, exp_stb);
        else if (wx > 0)
            chk(stb == exp_stb, "R6", "strobe length with hold", stb, exp_stb);
        else
            chk(stb == exp_stb, "R5", "strobe length", stb, exp_stb);
        chk(host_err == exp_err, "R8", "error flag", host_err, exp_err);
        if (!we) begin
            if (exp_err)
                chk(host_rdata == 8'hFF, "R8", "timeout read byte", host_rdata, 8'hFF);
            else
                chk(host_rdata == 8'(model), "R7", "read byte", host_rdata, model);
        end
        @(negedge clk);
        chk(!host_ack, "R3", "ack one clock", host_ack, 0);
        if (!we && !exp_err)
            chk(host_rdata == 8'(model), "R7", "read byte held", host_rdata, model);
        if (poke) begin
            @(negedge clk);
            chk(pb_cs_n == 8'hFF && !host_ack, "R9", "no cycle from busy request",
                pb_cs_n, 8'hFF);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pb_cs_n == 8'hFF && pb_rd_n && pb_wr_n && !host_ack,
            "R1", "bus idle in reset", pb_cs_n, 8'hFF);
        rst_n = 1;
        @(negedge clk);
        chk(pb_cs_n == 8'hFF && pb_rd_n && pb_wr_n, "R1", "bus idle after reset",
            {pb_rd_n, pb_wr_n, pb_cs_n}, 10'h3FF);
        chk(!host_ack && !host_err, "R1", "ack/err after reset",
            {host_ack, host_err}, 0);
        chk(irq_status == 2'b00 && !irq_out, "R1", "irq after reset",
            {irq_out, irq_status}, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_access(VECS[v].we, int'(VECS[v].dev), int'(VECS[v].addr),
                       int'(VECS[v].wd), int'(VECS[v].model),
                       int'(VECS[v].rdly), int'(VECS[v].wx), 1'b0, 1'b0);
        end

        // R9: request during a busy cycle
        run_access(1'b0, 2, 6, 0, 8'h69, 2, 1, 1'b0, 1'b1);

        // R8: timeout on a read, then error clears on next accepted request
        run_access(1'b0, 4, 3, 0, 8'h12, 1000, 0, 1'b1, 1'b0);
        run_access(1'b0, 4, 3, 0, 8'h34, 0, 0, 1'b0, 1'b0);
        // R8: timeout on a write
        run_access(1'b1, 0, 1, 8'h9D, 0, 1000, 0, 1'b1, 1'b0);

        // R10/R11: interrupt latch
        irq_en = 2'b01;
        pb_irq = 2'b01;
        @(negedge clk);
        chk(irq_status == 2'b01, "R10", "edge sets bit0", irq_status, 1);
        chk(irq_out, "R11", "enabled bit drives out", irq_out, 1);
        pb_irq = 2'b00;
        @(negedge clk);
        chk(irq_status == 2'b01, "R10", "bit stays after line drops", irq_status, 1);
        pb_irq = 2'b10;
        @(negedge clk);
        chk(irq_status == 2'b11, "R10", "edge sets bit1", irq_status, 3);
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk(irq_status == 2'b10, "R10", "clear bit0 only", irq_status, 2);
        chk(!irq_out, "R11", "masked bit gives no out", irq_out, 0);
        irq_en = 2'b11;
        @(negedge clk);
        chk(irq_out, "R11", "enabling bit1", irq_out, 1);
        irq_clr = 2'b10;
        @(negedge clk);
        irq_clr = 2'b00;
        @(negedge clk);
        chk(irq_status == 2'b00, "R10", "level held gives no new set", irq_status, 0);
        chk(!irq_out, "R11", "out low when none set", irq_out, 0);
        pb_irq = 2'b00;
        @(negedge clk);
        pb_irq = 2'b01;
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk(irq_status == 2'b01, "R10", "edge beats clear", irq_status, 1);
        pb_irq = 2'b00;
        @(negedge clk);
        summary();
    end
endmodule